// File: doc/BRIEF.md
# Smart Card Receive Error-Signal Controller

This block makes the receive-side error decisions for a character-oriented smart card link that uses the T=0 protocol. A separate receiver hands it two things for each character: a one-cycle strobe that says a character is complete, and the parity verdict for that character. From these the block decides whether the byte is accepted or whether the card must be asked to repeat it. To ask for a repeat, it pulses an error-signal (NACK) request that the line driver turns into a low level during the guard time.

Three policies are selectable. In the accept mode, errored bytes are taken without any error signal. In the plain mode, every parity error is signalled. In the capped mode, successive errors are signalled only up to a programmable limit of 0 to 7. The next error after that is taken silently, and a sticky iteration flag is raised. In every mode, a saturating tally counts parity errors, and a read strobe clears it. A receive-ready status bit, gated by an enable, drives an interrupt line.

The character strobe is a plain event with no back-pressure. The receiver holds no data for this block, so there is no valid/ready pairing. All configuration, command and status pins are level or pulse signals sampled on the rising clock edge.

Top module: `sc_rx_errsig`

## Requirements
- R1: A character with good parity (`parity_ok`=1 with `char_done`) raises no NACK and sets `rx_ready` one cycle later. It also clears the successive-error count to zero.
- R2: When `cfg_accept_bad`=1, a parity error raises no NACK and sets `rx_ready` one cycle later. This holds whatever the other mode bits are.
- R3: When `cfg_accept_bad`=0 and `cfg_cap_en`=0, every parity error raises `nack_req` one cycle later and leaves `rx_ready` unchanged.
- R4: When `cfg_accept_bad`=0 and `cfg_cap_en`=1, each parity error is handled according to the successive-error count.
  - If the count is below `cfg_rep_limit`, the error raises a NACK and the count increases by one.
  - If the count has reached `cfg_rep_limit`, the error raises no NACK. The byte is accepted (`rx_ready` is set), `iter_flag` is set and the count returns to zero.
  - With a limit of 0, the very first error is silent.
- R5: `iter_flag` stays set until `cmd_clr_iter` is pulsed. When a setting event and `cmd_clr_iter` fall in the same cycle, the flag ends up set.
- R6: `err_count` (8 bits) increases by one for every character with a parity error, in every mode. It saturates at 255.
- R7: A pulse on `err_rd` clears `err_count` to 0 on the next cycle. When `err_rd` and a parity error fall in the same cycle, `err_count` becomes 1.
- R8: `nack_req` is a single-cycle pulse. It is high only in the cycle right after a `char_done` that carried a parity error.
- R9: `rx_ready` stays set until `rx_ack` is pulsed, and setting wins over a clear in the same cycle. `irq` equals `rx_ready` AND `irq_en`, with no delay.
- R10: After reset, `nack_req`, `rx_ready`, `irq`, `iter_flag` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a character has been received |
| parity_ok | input | 1 | Parity verdict, valid with `char_done` (1 = good) |
| cfg_accept_bad | input | 1 | Accept errored bytes without signalling |
| cfg_cap_en | input | 1 | Cap successive error signals at `cfg_rep_limit` |
| cfg_rep_limit | input | 3 | Successive-error limit, 0 to 7 |
| cmd_clr_iter | input | 1 | Pulse: clear `iter_flag` |
| err_rd | input | 1 | Pulse: tally is being read, clear it |
| rx_ack | input | 1 | Pulse: clear `rx_ready` |
| irq_en | input | 1 | Interrupt enable for `rx_ready` |
| nack_req | output | 1 | Request to drive the error signal in the guard time |
| rx_ready | output | 1 | Sticky status: a byte was accepted |
| irq | output | 1 | Receive interrupt |
| iter_flag | output | 1 | Sticky status: the repetition limit was reached |
| err_count | output | 8 | Saturating parity-error tally |

## Verification
Two pairs of functions can land in the same cycle:
- An error character and a tally read. The bench raises `err_rd` in the same cycle as an errored `char_done`, after first driving the tally to saturation. It then expects a count of exactly 1, rather than 0 or 255.
- A limit hit and a flag-clear command. The bench pulses `cmd_clr_iter` together with the silent error that reaches a limit of 0. It expects `iter_flag` still set in the next cycle.

Clearing `rx_ready` together with a fresh accepted byte is covered in the same way, with the set expected to win.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  // Per-character outcome computed by the decision stage.
  typedef struct packed {
    logic nack;      // ask for a repetition
    logic accept;    // byte goes up as received
    logic hit_limit; // repetition limit reached
    logic bad;       // parity error seen
  } rx_verdict_t;
endpackage

// File: rtl/sc_nack_decider.sv
module sc_nack_decider
  import sc_rx_pkg::*;
#(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic              parity_ok,
  input  logic              accept_bad,
  input  logic              cap_en,
  input  logic [ITER_W-1:0] rep_limit,
  output rx_verdict_t       verdict
);
  localparam logic [ITER_W-1:0] STEP = ITER_W'(1);

  logic [ITER_W-1:0] run_q, run_d;

  always_comb begin
    verdict = '0;
    run_d   = run_q;
    if (!cap_en) run_d = '0;
    if (char_done) begin
      verdict.bad = !parity_ok;
      if (parity_ok) begin
        verdict.accept = 1'b1;
        run_d          = '0;
      end else if (accept_bad) begin
        verdict.accept = 1'b1;
      end else if (!cap_en) begin
        verdict.nack = 1'b1;
      end else if (run_q < rep_limit) begin
        verdict.nack = 1'b1;
        run_d        = run_q + STEP;
      end else begin
        verdict.accept    = 1'b1;
        verdict.hit_limit = 1'b1;
        run_d             = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/sc_err_tally.sv
module sc_err_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             rd,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] base;

  always_comb base = rd ? '0 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (bump && base != TOP) count <= base + STEP;
    else                          count <= base;
  end
endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ready,
  input  logic clr_ready,
  input  logic set_iter,
  input  logic clr_iter,
  input  logic irq_en,
  output logic rx_ready,
  output logic iter_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      iter_flag <= 1'b0;
    end else begin
      if (set_ready)      rx_ready <= 1'b1;
      else if (clr_ready) rx_ready <= 1'b0;
      if (set_iter)       iter_flag <= 1'b1;
      else if (clr_iter)  iter_flag <= 1'b0;
    end
  end

  assign irq = rx_ready & irq_en;
endmodule

// File: rtl/sc_rx_errsig.sv
module sc_rx_errsig
  import sc_rx_pkg::*;
#(
  parameter int ITER_W  = 3,
  parameter int TALLY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               char_done,
  input  logic               parity_ok,
  input  logic               cfg_accept_bad,
  input  logic               cfg_cap_en,
  input  logic [ITER_W-1:0]  cfg_rep_limit,
  input  logic               cmd_clr_iter,
  input  logic               err_rd,
  input  logic               rx_ack,
  input  logic               irq_en,
  output logic               nack_req,
  output logic               rx_ready,
  output logic               irq,
  output logic               iter_flag,
  output logic [TALLY_W-1:0] err_count
);
  rx_verdict_t verdict;

  sc_nack_decider #(.ITER_W(ITER_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (char_done),
    .parity_ok  (parity_ok),
    .accept_bad (cfg_accept_bad),
    .cap_en     (cfg_cap_en),
    .rep_limit  (cfg_rep_limit),
    .verdict    (verdict)
  );

  sc_err_tally #(.CNT_W(TALLY_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (verdict.bad),
    .rd    (err_rd),
    .count (err_count)
  );

  sc_rx_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ready (verdict.accept),
    .clr_ready (rx_ack),
    .set_iter  (verdict.hit_limit),
    .clr_iter  (cmd_clr_iter),
    .irq_en    (irq_en),
    .rx_ready  (rx_ready),
    .iter_flag (iter_flag),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nack_req <= 1'b0;
    else        nack_req <= verdict.nack;
  end
endmodule

// File: rtl/sc_rx_errsig_chk.sv
module sc_rx_errsig_chk #(
  parameter int ITER_W  = 3,
  parameter int TALLY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               char_done,
  input logic               parity_ok,
  input logic               cfg_accept_bad,
  input logic               cfg_cap_en,
  input logic [ITER_W-1:0]  cfg_rep_limit,
  input logic               cmd_clr_iter,
  input logic               err_rd,
  input logic               rx_ack,
  input logic               irq_en,
  input logic               nack_req,
  input logic               rx_ready,
  input logic               irq,
  input logic               iter_flag,
  input logic [TALLY_W-1:0] err_count
);
  localparam logic [TALLY_W-1:0] TOP = '1;

  assert_good_char_R1: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && parity_ok |=> rx_ready && !nack_req);

  assert_accept_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !parity_ok && cfg_accept_bad |=> rx_ready && !nack_req);

  assert_plain_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !parity_ok && !cfg_accept_bad && !cfg_cap_en |=> nack_req);

  assert_zero_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !parity_ok && !cfg_accept_bad && cfg_cap_en && cfg_rep_limit == '0
    |=> !nack_req && iter_flag && rx_ready);

  assert_iter_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iter_flag && !cmd_clr_iter |=> iter_flag);

  assert_tally_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == TOP && !err_rd |=> err_count == TOP);

  assert_read_with_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd && char_done && !parity_ok |=> err_count == TALLY_W'(1));

  assert_nack_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |-> $past(char_done) && !$past(parity_ok));

  assert_ready_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && !char_done |=> !rx_ready);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_ready && irq_en);
endmodule

bind sc_rx_errsig sc_rx_errsig_chk #(.ITER_W(ITER_W), .TALLY_W(TALLY_W)) u_chk (.*);

// File: tb/sc_rx_errsig_test.sv
module sc_rx_errsig_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_done = 1'b0, parity_ok = 1'b1;
  logic       cfg_accept_bad = 1'b0, cfg_cap_en = 1'b0;
  logic [2:0] cfg_rep_limit = 3'd0;
  logic       cmd_clr_iter = 1'b0, err_rd = 1'b0, rx_ack = 1'b0, irq_en = 1'b0;
  logic       nack_req, rx_ready, irq, iter_flag;
  logic [7:0] err_count;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_rx_errsig uut (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .parity_ok(parity_ok),
    .cfg_accept_bad(cfg_accept_bad), .cfg_cap_en(cfg_cap_en),
    .cfg_rep_limit(cfg_rep_limit), .cmd_clr_iter(cmd_clr_iter),
    .err_rd(err_rd), .rx_ack(rx_ack), .irq_en(irq_en),
    .nack_req(nack_req), .rx_ready(rx_ready), .irq(irq),
    .iter_flag(iter_flag), .err_count(err_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one character at a falling edge; return at the next falling
  // edge, where the registered response is visible.
  task automatic send_char(input logic ok);
    char_done = 1'b1;
    parity_ok = ok;
    @(negedge clk);
    char_done = 1'b0;
    parity_ok = 1'b1;
  endtask

  task automatic ack_ready();
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  task automatic read_tally();
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 nack", int'(nack_req), 0);
    check("R10 ready", int'(rx_ready), 0);
    check("R10 irq", int'(irq), 0);
    check("R10 iter", int'(iter_flag), 0);
    check("R10 count", int'(err_count), 0);
  endtask

  task automatic t_good_char();
    irq_en = 1'b0;
    send_char(1'b1);
    check("R1 ready", int'(rx_ready), 1);
    check("R1 nack", int'(nack_req), 0);
    check("R9 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    #1 check("R9 irq enabled", int'(irq), 1);
    @(negedge clk);
    ack_ready();
    check("R9 ready cleared", int'(rx_ready), 0);
    check("R9 irq cleared", int'(irq), 0);
    rx_ack = 1'b1;
    send_char(1'b1);
    rx_ack = 1'b0;
    check("R9 set beats clear", int'(rx_ready), 1);
    ack_ready();
  endtask

  task automatic t_plain();
    cfg_accept_bad = 1'b0;
    cfg_cap_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      send_char(1'b0);
      check("R3 nack", int'(nack_req), 1);
      check("R3 no ready", int'(rx_ready), 0);
      @(negedge clk);
      check("R8 single pulse", int'(nack_req), 0);
    end
  endtask

  task automatic t_accept_bad();
    cfg_accept_bad = 1'b1;
    cfg_cap_en = 1'b1;
    cfg_rep_limit = 3'd3;
    send_char(1'b0);
    check("R2 no nack", int'(nack_req), 0);
    check("R2 ready", int'(rx_ready), 1);
    ack_ready();
    cfg_accept_bad = 1'b0;
  endtask

  task automatic t_cap();
    cfg_cap_en = 1'b1;
    cfg_rep_limit = 3'd2;
    send_char(1'b0);
    check("R4 first nack", int'(nack_req), 1);
    send_char(1'b0);
    check("R4 second nack", int'(nack_req), 1);
    send_char(1'b0);
    check("R4 silent at limit", int'(nack_req), 0);
    check("R4 flag", int'(iter_flag), 1);
    check("R4 accepted", int'(rx_ready), 1);
    ack_ready();
    send_char(1'b0);
    check("R4 count restarts", int'(nack_req), 1);
    send_char(1'b1);
    send_char(1'b0);
    check("R1 count cleared a", int'(nack_req), 1);
    send_char(1'b0);
    check("R1 count cleared b", int'(nack_req), 1);
    repeat (3) @(negedge clk);
    check("R5 flag held", int'(iter_flag), 1);
    cmd_clr_iter = 1'b1;
    @(negedge clk);
    cmd_clr_iter = 1'b0;
    check("R5 flag cleared", int'(iter_flag), 0);
    ack_ready();
  endtask

  task automatic t_zero_limit();
    cfg_cap_en = 1'b1;
    cfg_rep_limit = 3'd0;
    cmd_clr_iter = 1'b1;
    send_char(1'b0);
    cmd_clr_iter = 1'b0;
    check("R4 zero limit silent", int'(nack_req), 0);
    check("R5 set beats clear", int'(iter_flag), 1);
    cmd_clr_iter = 1'b1;
    @(negedge clk);
    cmd_clr_iter = 1'b0;
    ack_ready();
    cfg_cap_en = 1'b0;
  endtask

  task automatic t_tally();
    int exp_cnt;
    read_tally();
    check("R7 read clears", int'(err_count), 0);
    cfg_accept_bad = 1'b1;
    exp_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      send_char(1'b0);
      exp_cnt++;
    end
    send_char(1'b1);
    check("R6 counts errors only", int'(err_count), exp_cnt);
    for (int i = 0; i < 260; i++) send_char(1'b0);
    check("R6 saturates", int'(err_count), 255);
    err_rd = 1'b1;
    send_char(1'b0);
    err_rd = 1'b0;
    check("R7 read with error", int'(err_count), 1);
    cfg_accept_bad = 1'b0;
    ack_ready();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_good_char();
    t_plain();
    t_accept_bad();
    t_cap();
    t_zero_limit();
    t_tally();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule